// File: doc/BRIEF.md
# Timer Output-Compare Pin Arbiter

This block produces the output level of one general-purpose port pin that a timer can also take over. Three sources compete for the pin. The first is a plain output data bit written by software. The second is a shared master compare channel that can drive many pins through a per-pin mask and a per-pin data bit. The third is the pin's own dedicated compare channel, which has two mode bits that select toggle, drive-low or drive-high.

The pin level is held in a register. That register changes only on a single-cycle update strobe, which stands for the pin-change clock aligned to the falling edge of the bus clock. A compare match or a force write on either channel is held as pending until the next strobe, and that strobe consumes it.

On each strobe a fixed priority picks the new level:
- The master channel wins over the dedicated channel.
- The dedicated channel computes its next level from its mode and the pin level before the update.
- The plain output bit reaches the pin only when no timer function owns the pin.

Top module: `oc_pin_arbiter`

## Requirements
- R1: While rst_ni is low, pin_o is 0 and no event is pending. The first strobe after reset with no new event applies no timer update.
- R2: pin_o changes only in the cycle that follows a cycle with upd_stb_i high. Events without a strobe leave pin_o unchanged.
- R3: On a strobe with mst_mask_i = 0 and ded_mode_i = 2'b00, pin_o takes the value gp_data_i had in the strobe cycle.
- R4: When mst_mask_i = 1 or ded_mode_i is not 2'b00, gp_data_i has no effect. A strobe with no pending or new event leaves pin_o unchanged.
- R5: On a strobe with mst_mask_i = 1 and a master event (mst_match_i or mst_force_i high in that cycle, or latched since the last strobe), pin_o takes mst_data_i.
- R6: On a strobe with a dedicated event and the dedicated channel enabled, the new level follows ded_mode_i. 2'b01 inverts the previous pin_o, 2'b10 drives 0, and 2'b11 drives 1. This applies when no master event is acting.
- R7: If a master event acts (R5) on the same strobe as a dedicated event, the master value is applied and the dedicated update is suppressed.
- R8: An event is consumed by exactly one strobe. A second strobe with no new event produces no further timer update, so repeated toggles need one event each.
- R9: With mst_mask_i = 1 but no master event on a strobe, a dedicated event acts normally as in R6.
- R10: With ded_mode_i = 2'b00, dedicated match and force events have no effect on pin_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_stb_i | input | 1 | One-cycle pin update strobe |
| gp_data_i | input | 1 | General-purpose output data bit |
| mst_mask_i | input | 1 | Master channel owns this pin |
| mst_data_i | input | 1 | Level the master channel applies |
| mst_match_i | input | 1 | Master compare match pulse |
| mst_force_i | input | 1 | Master force write pulse |
| ded_mode_i | input | 2 | Dedicated mode: 00 off, 01 toggle, 10 low, 11 high |
| ded_match_i | input | 1 | Dedicated compare match pulse |
| ded_force_i | input | 1 | Dedicated force write pulse |
| pin_o | output | 1 | Pin level |

## Verification
A master event and a dedicated event can land on the same update strobe. That collision is the case that must resolve to the master value while the dedicated result is dropped.

The bench sweeps every combination of the following:
- mask and mode;
- event presence on each channel;
- master data, general-purpose data and previous pin level;
- whether the events arrive before the strobe or in the strobe cycle itself.

The previous pin level is chosen so that a toggling dedicated channel and the master data would disagree. This means a wrongly granted dedicated update shows at the pin. Each sweep point is judged against a priority model written in the bench, and a follow-up strobe without events then confirms that the event was consumed once.

// File: rtl/oc_pin_pkg.sv
package oc_pin_pkg;
  typedef enum logic [1:0] {
    OC_OFF    = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_LOW    = 2'b10,
    OC_HIGH   = 2'b11
  } oc_mode_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_MST = 0;
  localparam int unsigned CH_DED = 1;
endpackage

// File: rtl/oc_event_pend.sv
module oc_event_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic force_i,
  input  logic upd_i,
  output logic eff_o,
  output logic pend_q_o
);
  logic pend_q;

  // event in the strobe cycle is consumed by that strobe
  assign eff_o    = pend_q | match_i | force_i;
  assign pend_q_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (upd_i) pend_q <= 1'b0;
    else            pend_q <= eff_o;
  end
endmodule

// File: rtl/oc_ded_next.sv
module oc_ded_next
  import oc_pin_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       prev_i,
  output logic       en_o,
  output logic       nxt_o
);
  oc_mode_e mode;
  assign mode = oc_mode_e'(mode_i);
  assign en_o = (mode != OC_OFF);

  always_comb begin
    unique case (mode)
      OC_TOGGLE: nxt_o = ~prev_i;
      OC_LOW:    nxt_o = 1'b0;
      OC_HIGH:   nxt_o = 1'b1;
      default:   nxt_o = prev_i;
    endcase
  end
endmodule

// File: rtl/oc_pin_sel.sv
module oc_pin_sel #(
  parameter bit PIN_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic gp_data_i,
  input  logic mst_mask_i,
  input  logic mst_eff_i,
  input  logic mst_data_i,
  input  logic ded_en_i,
  input  logic ded_eff_i,
  input  logic ded_nxt_i,
  output logic pin_o
);
  logic pin_q, pin_d;
  logic mst_act, ded_act, gp_own;

  assign mst_act = mst_mask_i & mst_eff_i;
  assign ded_act = ded_en_i & ded_eff_i & ~mst_act;  // master overrides
  assign gp_own  = ~mst_mask_i & ~ded_en_i;

  always_comb begin
    pin_d = pin_q;
    if (upd_i) begin
      if (mst_act)      pin_d = mst_data_i;
      else if (ded_act) pin_d = ded_nxt_i;
      else if (gp_own)  pin_d = gp_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= PIN_RST;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/oc_pin_arbiter.sv
module oc_pin_arbiter
  import oc_pin_pkg::*;
#(
  parameter bit PIN_RST = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_stb_i,
  input  logic       gp_data_i,
  input  logic       mst_mask_i,
  input  logic       mst_data_i,
  input  logic       mst_match_i,
  input  logic       mst_force_i,
  input  logic [1:0] ded_mode_i,
  input  logic       ded_match_i,
  input  logic       ded_force_i,
  output logic       pin_o
);
  logic [NUM_CH-1:0] ch_match, ch_force, ch_eff, ch_pend_q;
  logic ded_en, ded_nxt, pin_q;

  assign ch_match[CH_MST] = mst_match_i;
  assign ch_force[CH_MST] = mst_force_i;
  assign ch_match[CH_DED] = ded_match_i;
  assign ch_force[CH_DED] = ded_force_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    oc_event_pend u_pend (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .match_i  (ch_match[c]),
      .force_i  (ch_force[c]),
      .upd_i    (upd_stb_i),
      .eff_o    (ch_eff[c]),
      .pend_q_o (ch_pend_q[c])
    );
  end

  // previous level comes from the pin register, stable through the update
  oc_ded_next u_next (
    .mode_i (ded_mode_i),
    .prev_i (pin_q),
    .en_o   (ded_en),
    .nxt_o  (ded_nxt)
  );

  oc_pin_sel #(.PIN_RST(PIN_RST)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd_stb_i),
    .gp_data_i  (gp_data_i),
    .mst_mask_i (mst_mask_i),
    .mst_eff_i  (ch_eff[CH_MST]),
    .mst_data_i (mst_data_i),
    .ded_en_i   (ded_en),
    .ded_eff_i  (ch_eff[CH_DED]),
    .ded_nxt_i  (ded_nxt),
    .pin_o      (pin_q)
  );

  assign pin_o = pin_q;
endmodule

// File: rtl/oc_pin_arbiter_chk.sv
module oc_pin_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       upd_stb_i,
  input logic       gp_data_i,
  input logic       mst_mask_i,
  input logic       mst_data_i,
  input logic       mst_match_i,
  input logic       mst_force_i,
  input logic [1:0] ded_mode_i,
  input logic       ded_match_i,
  input logic       ded_force_i,
  input logic       pin_o,
  input logic [1:0] pend_i
);
  logic mev, dev;
  assign mev = mst_match_i | mst_force_i | pend_i[0];
  assign dev = ded_match_i | ded_force_i | pend_i[1];

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_stb_i |=> $stable(pin_o));

  p_gp_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_i && !mst_mask_i && ded_mode_i == 2'b00 |=> pin_o == $past(gp_data_i));

  p_gp_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_i && (mst_mask_i || ded_mode_i != 2'b00) && !mev && !dev |=> $stable(pin_o));

  p_master_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_i && mst_mask_i && mev |=> pin_o == $past(mst_data_i));

  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_i && ded_mode_i == 2'b01 && dev && !(mst_mask_i && mev) |=> pin_o != $past(pin_o));

  p_master_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_i && mst_mask_i && mev && dev && ded_mode_i == 2'b01 && mst_data_i == pin_o
    |=> $stable(pin_o));

  p_consume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_stb_i |=> pend_i == 2'b00);
endmodule

bind oc_pin_arbiter oc_pin_arbiter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_stb_i   (upd_stb_i),
  .gp_data_i   (gp_data_i),
  .mst_mask_i  (mst_mask_i),
  .mst_data_i  (mst_data_i),
  .mst_match_i (mst_match_i),
  .mst_force_i (mst_force_i),
  .ded_mode_i  (ded_mode_i),
  .ded_match_i (ded_match_i),
  .ded_force_i (ded_force_i),
  .pin_o       (pin_o),
  .pend_i      (ch_pend_q)
);

// File: tb/oc_pin_arbiter_tb.sv
module oc_pin_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 0, gp = 0, mask = 0, mdata = 0, mmatch = 0, mforce = 0;
  logic [1:0] mode = 2'b00;
  logic dmatch = 0, dforce = 0;
  logic pin;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  oc_pin_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .upd_stb_i(upd), .gp_data_i(gp),
    .mst_mask_i(mask), .mst_data_i(mdata), .mst_match_i(mmatch), .mst_force_i(mforce),
    .ded_mode_i(mode), .ded_match_i(dmatch), .ded_force_i(dforce), .pin_o(pin)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pin=%b expected=%b (mask=%b mode=%b)", req, act, exp, mask, mode);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_in();
    upd = 0; mmatch = 0; mforce = 0; dmatch = 0; dforce = 0;
  endtask

  // put the pin at a known level via the general-purpose path
  task automatic preset(logic v);
    clear_in(); mask = 0; mode = 2'b00; gp = v; upd = 1;
    step();
    upd = 0;
  endtask

  function automatic logic model(logic m, logic [1:0] md, logic me, logic de,
                                 logic mdat, logic g, logic prev);
    if (m && me) return mdat;
    if (md != 2'b00 && de) begin
      if (md == 2'b01) return ~prev;
      if (md == 2'b10) return 1'b0;
      return 1'b1;
    end
    if (!m && md == 2'b00) return g;
    return prev;
  endfunction

  function automatic string tag(logic m, logic [1:0] md, logic me, logic de);
    if (m && me && de && md != 2'b00) return "R7";
    if (m && me) return "R5";
    if (md != 2'b00 && de && m) return "R9";
    if (md != 2'b00 && de) return "R6";
    if (md == 2'b00 && de && !m) return "R10";
    if (!m && md == 2'b00) return "R3";
    return "R4";
  endfunction

  initial begin
    repeat (3) step();
    check("R1", pin, 1'b0);
    rst_n = 1;
    // R1: first strobe after reset, timer owns pin, no events -> stays 0
    mask = 1; mode = 2'b01; upd = 1; step(); upd = 0;
    check("R1", pin, 1'b0);

    for (int cfg = 0; cfg < 512; cfg++) begin
      logic m, me, de, mdat, g, prev, same;
      logic [1:0] md;
      logic exp;
      m = cfg[0]; md = cfg[2:1]; me = cfg[3]; de = cfg[4];
      mdat = cfg[5]; g = cfg[6]; prev = cfg[7]; same = cfg[8];
      preset(prev);
      check("R3", pin, prev);
      mask = m; mode = md; mdata = mdat; gp = g;
      mmatch = me & cfg[6]; mforce = me & ~cfg[6];
      dmatch = de & cfg[5]; dforce = de & ~cfg[5];
      upd = same;
      step();
      if (!same) begin
        mmatch = 0; mforce = 0; dmatch = 0; dforce = 0;
        check("R2", pin, prev);
        upd = 1;
        step();
      end
      clear_in();
      exp = model(m, md, me, de, mdat, g, prev);
      check(tag(m, md, me, de), pin, exp);
      // R8: strobe again without events
      upd = 1; step(); upd = 0;
      check("R8", pin, model(m, md, 1'b0, 1'b0, mdat, g, exp));
    end

    // R8: repeated toggles, one force each
    preset(1'b0);
    mask = 0; mode = 2'b01;
    for (int i = 0; i < 4; i++) begin
      dforce = 1; step(); dforce = 0;
      check("R2", pin, i[0]);
      upd = 1; step(); upd = 0;
      check("R8", pin, ~i[0]);
    end

    // R4: general-purpose writes under timer ownership, no strobe events
    mode = 2'b11; mask = 0;
    for (int i = 0; i < 2; i++) begin
      logic held;
      held = pin;
      gp = ~held; upd = 1; step(); upd = 0;
      check("R4", pin, held);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule